// File: doc/BRIEF.md
# Interrupt Status and Flag Summarizer

This block keeps a ten-bit sticky interrupt-status register for a switch-monitoring interface that is controlled over SPI. Each bit is set by a one-cycle event pulse from a neighbouring unit. These units are the reset logic, the SPI frame-length checker, the parity checker, switch-change detection, the temperature monitor and the supply and CRC monitors. A bit stays set until software reads the status register.

From the register the block builds a seven-bit flag summary. The SPI slave shifts this summary out at the start of every frame. The block also drives a registered active-low interrupt pin, which is low while any sticky bit is set.

A small read-tracking state machine sees chip select (`cs_n_i`, already synchronous to `clk`) and a decoded "this frame reads the status register" pulse (`rd_stat_i`). It has three states:
- RD_IDLE: chip select is high.
- RD_FRAME: a frame is running and the status register has not been read.
- RD_ARMED: a frame is running and the status register has been read.

It has five transitions:
- IDLE to FRAME: chip select falls without a read.
- IDLE or FRAME to ARMED: chip select is low and `rd_stat_i` is high.
- FRAME to IDLE: chip select rises.
- ARMED to IDLE: chip select rises. This transition also produces the clear.
- ARMED stays in ARMED while chip select stays low.

Top module: `irq_flag_summary`

## Requirements
- R1: During reset and after it, the register holds only the power-on bit (`stat_o` = 10'h200), `flags_o` = 7'b1000000 and `irq_n_o` = 0.
- R2: Register bit positions are: [9] power-on, [8] frame length error, [7] parity error, [6] switch change, [5] temperature warning change, [4] temperature shutdown change, [3] overvoltage, [2] undervoltage, [1] CRC calculation, [0] check fail. A pulse on `evt_i[k]` sets `stat_o[k]` at the next clock edge. The bit stays set until a clear.
- R3: `flags_o` bits, from bit 6 down to bit 0, are: power-on, frame length error, parity error, switch change, reserved, temperature, other. Bits 6 to 3 mirror register bits 9 to 6.
- R4: The reserved flag, `flags_o[2]`, is always 0.
- R5: The temperature flag, `flags_o[1]`, is the OR of register bits 5 and 4. The warning and shutdown monitors pulse these bits both when their condition starts and when it ends.
- R6: The other flag, `flags_o[0]`, is the OR of register bits 3 to 0.
- R7: `irq_n_o` is low exactly when some register bit is set. It is registered and changes at the same edge as `stat_o`.
- R8: The clock edge at which `cs_n_i` is first seen high again after a frame in which `rd_stat_i` was high clears the whole register.
- R9: A frame without `rd_stat_i`, or an `rd_stat_i` pulse while `cs_n_i` is high, clears nothing.
- R10: An event pulse in the same cycle as a clear wins, so its bit is set after the clear.
- R11: A software or hardware reset event on `evt_i[9]` sets the power-on bit without resetting the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 10 | One-cycle event pulses, positions as in R2 |
| cs_n_i | input | 1 | SPI chip select, active low, synchronous |
| rd_stat_i | input | 1 | Current frame is a read of the status register |
| stat_o | output | 10 | Sticky status register |
| flags_o | output | 7 | Flag summary shifted at the start of each frame |
| irq_n_o | output | 1 | Active-low interrupt pin |

## Verification
The bench targets the following corner cases:
- An event that collides with the clear edge. A design that gave the clear priority would silently lose that event.
- A frame that never reads the status register, and a read pulse while chip select is high. A design that cleared on any chip-select rising edge would drop pending interrupts.
- Each event bit on its own, checked through the flag map. This catches swapped flag positions, a temperature or other flag that misses one of its sources, and an interrupt pin that lags the register by a cycle.
- Random traffic with a fixed seed, compared every cycle against a bench model. This exercises back-to-back frames and events that arrive during an armed read.

// File: rtl/irq_sum_pkg.sv
package irq_sum_pkg;
    localparam int STAT_W = 10;
    localparam int FLAG_W = 7;

    // register bit positions
    localparam int B_POR  = 9;
    localparam int B_LEN  = 8;
    localparam int B_PAR  = 7;
    localparam int B_SSC  = 6;
    localparam int B_TW   = 5;
    localparam int B_TSD  = 4;
    localparam int B_OV   = 3;
    localparam int B_UV   = 2;
    localparam int B_CRC  = 1;
    localparam int B_CHK  = 0;

    // summary flag positions
    localparam int F_POR  = 6;
    localparam int F_LEN  = 5;
    localparam int F_PAR  = 4;
    localparam int F_SSC  = 3;
    localparam int F_RES  = 2;
    localparam int F_TEMP = 1;
    localparam int F_OTH  = 0;

    localparam int MIRROR_N = 4;

    typedef enum logic [1:0] {
        RD_IDLE  = 2'd0,
        RD_FRAME = 2'd1,
        RD_ARMED = 2'd2
    } rd_state_e;
endpackage

// File: rtl/irq_read_fsm.sv
module irq_read_fsm
    import irq_sum_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic rd_stat,
    output logic clr
);
    rd_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RD_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_IDLE: begin
                if (!cs_n) state_d = rd_stat ? RD_ARMED : RD_FRAME;
            end
            RD_FRAME: begin
                if (cs_n)         state_d = RD_IDLE;
                else if (rd_stat) state_d = RD_ARMED;
            end
            RD_ARMED: begin
                if (cs_n) state_d = RD_IDLE;
            end
            default: state_d = RD_IDLE;
        endcase
    end

    always_comb begin
        clr = 1'b0;
        unique case (state_q)
            RD_ARMED: clr = cs_n;
            default:  clr = 1'b0;
        endcase
    end

    AST_CLR_ON_CS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        clr |-> (cs_n && $past(!cs_n))); // R8
endmodule

// File: rtl/irq_sticky_reg.sv
module irq_sticky_reg #(
    parameter int W = 10,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    input  logic         clr,
    output logic [W-1:0] stat_q,
    output logic [W-1:0] stat_nxt
);
    // events win over a clear in the same cycle
    always_comb stat_nxt = (clr ? '0 : stat_q) | evt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= RST_VAL;
        else        stat_q <= stat_nxt;
    end

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((stat_q & $past(stat_q)) == $past(stat_q))); // R2
    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((stat_q & $past(evt)) == $past(evt))); // R10
    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && evt == '0) |=> (stat_q == '0)); // R8
endmodule

// File: rtl/irq_flag_map.sv
module irq_flag_map
    import irq_sum_pkg::*;
(
    input  logic [STAT_W-1:0] stat,
    output logic [FLAG_W-1:0] flags
);
    localparam int OTH_N = B_OV - B_CHK + 1;

    // direct mirrors of the upper four register bits
    for (genvar g = 0; g < MIRROR_N; g++) begin : g_mirror
        assign flags[F_SSC + g] = stat[B_SSC + g];
    end

    logic [OTH_N-1:0] oth_bits;
    assign oth_bits = stat[B_OV:B_CHK];

    assign flags[F_RES]  = 1'b0;
    assign flags[F_TEMP] = stat[B_TW] | stat[B_TSD];
    assign flags[F_OTH]  = |oth_bits;
endmodule

// File: rtl/irq_flag_summary.sv
module irq_flag_summary
    import irq_sum_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] evt_i,
    input  logic              cs_n_i,
    input  logic              rd_stat_i,
    output logic [STAT_W-1:0] stat_o,
    output logic [FLAG_W-1:0] flags_o,
    output logic              irq_n_o
);
    localparam logic [STAT_W-1:0] STAT_RST = STAT_W'(1) << B_POR;

    logic              clr;
    logic [STAT_W-1:0] stat_nxt;

    irq_read_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (cs_n_i),
        .rd_stat (rd_stat_i),
        .clr     (clr)
    );

    irq_sticky_reg #(.W(STAT_W), .RST_VAL(STAT_RST)) u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt_i),
        .clr      (clr),
        .stat_q   (stat_o),
        .stat_nxt (stat_nxt)
    );

    irq_flag_map u_map (
        .stat  (stat_o),
        .flags (flags_o)
    );

    // registered pin, fed from the next register value so it stays aligned
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_n_o <= 1'b0;
        else        irq_n_o <= ~(|stat_nxt);
    end

    AST_IRQ_MATCHES_REG: assert property (@(posedge clk) disable iff (!rst_n)
        irq_n_o == ~(|stat_o)); // R7
    AST_POR_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i[B_POR] |=> flags_o[F_POR]); // R11
endmodule

// File: tb/irq_flag_summary_bench.sv
module irq_flag_summary_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] evt = '0;
    logic       cs_n = 1'b1;
    logic       rd = 1'b0;
    logic [9:0] stat;
    logic [6:0] flags;
    logic       irq_n;

    int total = 0;
    int bad = 0;
    logic [9:0] m_stat = 10'h200;
    logic       m_armed = 1'b0;
    bit         done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_flag_summary u_irq_flag_summary (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .cs_n_i(cs_n),
        .rd_stat_i(rd), .stat_o(stat), .flags_o(flags), .irq_n_o(irq_n)
    );

    function automatic logic [6:0] exp_flags(input logic [9:0] s);
        return {s[9], s[8], s[7], s[6], 1'b0, s[5] | s[4], |s[3:0]};
    endfunction

    task automatic check(input string req, input logic [17:0] act, input logic [17:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic check_all(input string req);
        check({req, " stat"}, {8'h0, stat}, {8'h0, m_stat});
        check({req, " flags"}, {11'h0, flags}, {11'h0, exp_flags(m_stat)});
        check({req, " irq"}, {17'h0, irq_n}, {17'h0, ~(|m_stat)});
    endtask

    // drive one cycle, advance the bench model, sample after the edge
    task automatic cyc(input logic [9:0] e, input logic c, input logic r);
        logic clr_m;
        evt = e; cs_n = c; rd = r;
        @(posedge clk);
        clr_m = m_armed & c;
        m_stat = (clr_m ? 10'h0 : m_stat) | e;
        m_armed = c ? 1'b0 : (m_armed | r);
        #1;
        evt = '0; rd = 1'b0;
    endtask

    task automatic read_clear();
        cyc('0, 1'b0, 1'b1);
        cyc('0, 1'b0, 1'b0);
        cyc('0, 1'b1, 1'b0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check_all("R1 reset");
        check("R1 por flag", {11'h0, flags}, {11'h0, 7'b1000000});
        rst_n = 1'b1;
        cyc('0, 1'b1, 1'b0);
        check_all("R1 after release");

        read_clear();
        check_all("R8 first clear");
        check("R8 empty", {8'h0, stat}, 18'h0);

        for (int i = 0; i < 10; i++) begin
            cyc(10'(1) << i, 1'b1, 1'b0);
            check_all("R2 R3 R5 R6 R7 single event");
            check("R4 res", {17'h0, flags[2]}, 18'h0);
            cyc('0, 1'b1, 1'b0);
            check_all("R2 sticky");
            read_clear();
            check_all("R8 clear after event");
        end

        // R5 temp start and end pulses
        cyc(10'h020, 1'b1, 1'b0); cyc('0, 1'b1, 1'b0); cyc(10'h020, 1'b1, 1'b0);
        check("R5 temp", {17'h0, flags[1]}, 18'h1);
        read_clear();

        // R9 frame without read, and read pulse while deselected
        cyc(10'h040, 1'b1, 1'b0);
        cyc('0, 1'b0, 1'b0); cyc('0, 1'b0, 1'b0); cyc('0, 1'b1, 1'b0);
        check("R9 no read frame", {8'h0, stat}, 18'h040);
        cyc('0, 1'b1, 1'b1); cyc('0, 1'b1, 1'b0);
        check("R9 rd while deselected", {8'h0, stat}, 18'h040);
        check_all("R9 model");

        // R10 event on the clear edge
        cyc('0, 1'b0, 1'b1);
        cyc(10'h001, 1'b1, 1'b0);
        check("R10 collision", {8'h0, stat}, 18'h001);
        check_all("R10 model");
        read_clear();

        // R11 software reset event
        cyc(10'h200, 1'b1, 1'b0);
        check("R11 por", {11'h0, flags}, {11'h0, 7'b1000000});
        read_clear();

        // random traffic
        void'($urandom(32'd4242));
        for (int n = 0; n < 3000; n++) begin
            logic [9:0] e;
            logic c, r;
            e = ($urandom % 6 == 0) ? (10'(1) << ($urandom % 10)) : 10'h0;
            c = ($urandom % 4 == 0) ? ~cs_n : cs_n;
            r = ($urandom % 3 == 0);
            cyc(e, c, r);
            check_all("R2 R7 R8 R9 R10 random");
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=hung exp=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule